// File: doc/BRIEF.md
# Dead-Zone-Free Phase-Frequency Detector

This block is a three-state phase-frequency detector for a frequency synthesizer loop. It watches two pulse trains: the divided reference and the divided feedback from the oscillator. Whichever input shows a rising edge first raises its own output. A reference edge raises `up_o` and a feedback edge raises `dn_o`. That output stays high until the other input's edge arrives. So the width of the lone pulse measures the phase error, and a repeated edge from the faster input shows up as a persistent one-sided output, which is how a frequency error appears.

Once both outputs are high, a common clear is held off by a programmable number of sample-clock cycles before both flip-flops drop together. As a result, every comparison produces a short pulse in which both outputs are high, even when the two edges coincide. This keeps the charge pump from sitting in a dead zone around zero phase error. The whole block runs synchronously on a sample clock that is much faster than either input. Each input level is reduced to a one-cycle rising-edge event before it reaches the state flip-flops. An edge that lands while the clear delay is running is kept and applied right after the clear.

Top module: `pfd_antibacklash`

## Requirements
- R1: While `rst_n` is low, `up_o` and `dn_o` are 0, and asserting reset clears outputs that were high.
- R2: With both outputs low, an input level on `ref_in` that was 0 in one sampled cycle and 1 in the next sets `up_o` one clock after the edge is sampled. `up_o` then stays high until `dn_o` has also been set and the clear delay ends.
- R3: With both outputs low, a rising edge on `fb_in` sets `dn_o` one clock after it is sampled. `dn_o` then stays high until `up_o` has also been set and the clear delay ends.
- R4: Only rising edges set the outputs: an input that stays high after a clear does not set its output again.
- R5: Both outputs fall on the same clock edge, after both have been high for D cycles. D is chosen by `width_code` as follows: 2'b00 gives 2, 2'b01 gives 1, 2'b10 gives 4, and 2'b11 gives 2.
- R6: When both inputs rise in the same sampled cycle, `up_o` and `dn_o` rise together and are high for exactly D cycles.
- R7: If one input leads the other by k sampled cycles, the leading output is high for k+D cycles and the lagging output for D cycles, and both end on the same edge.
- R8: A rising edge sampled while both outputs are high is held. Its output is set again on the clock edge right after the clear.
- R9: A second rising edge on an input whose output is already high, and which arrives before the other output is set, has no further effect.
- R10: D is taken from `width_code` as applied during the cycle whose clock edge completes the pair. Changing `width_code` while the delay runs does not change that delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, faster than either compared input |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Divided reference pulse train |
| fb_in | input | 1 | Divided feedback pulse train |
| width_code | input | 2 | Selects the overlap (clear delay) length |
| up_o | output | 1 | Charge-pump raise request |
| dn_o | output | 1 | Charge-pump lower request |

## Verification
Coincident edges are applied under all four width codes. This separates the delay table entries from one another and shows whether the outputs rise and fall as a pair. Skewed edges, with either input leading and with different lead lengths, check that the lone pulse widens by exactly the lead while the overlap length stays the same. Further directed sequences cover a retriggered edge in the middle of the delay, a doubled edge from the faster input, and a width-code change during the delay. These tell apart held, ignored and re-sampled events. A long stretch of seeded random toggling on both inputs and on the code is then compared cycle by cycle against a bench model. This reaches edges that land exactly on the clearing cycle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   localparam int unsigned N_CH   = 2;
   localparam int unsigned CH_REF = 0;
   localparam int unsigned CH_FB  = 1;

   // Overlap length selected by the two-bit width code.
   function automatic int unsigned pick_dly(
      input logic [1:0]  code,
      input int unsigned d00,
      input int unsigned d01,
      input int unsigned d10,
      input int unsigned d11
   );
      case (code)
         2'b00:   return d00;
         2'b01:   return d01;
         2'b10:   return d10;
         default: return d11;
      endcase
   endfunction

   function automatic int unsigned max4(
      input int unsigned a,
      input int unsigned b,
      input int unsigned c,
      input int unsigned d
   );
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);

   logic [N-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/pfd_chan_ff.sv
module pfd_chan_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic busy,
   input  logic expire,
   output logic q
);

   logic held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= 1'b0;
         held <= 1'b0;
      end else if (busy) begin
         if (ev)     held <= 1'b1;
         if (expire) q    <= 1'b0;
      end else begin
         q    <= q | ev | held;
         held <= 1'b0;
      end
   end

endmodule

// File: rtl/pfd_dly_ctr.sv
module pfd_dly_ctr #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic [CNT_W-1:0] load_m1,
   output logic             expire
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!busy)          cnt <= load_m1;
      else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
   end

   assign expire = busy && (cnt == '0);

endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash #(
   parameter int unsigned DLY_C00 = 2,
   parameter int unsigned DLY_C01 = 1,
   parameter int unsigned DLY_C10 = 4,
   parameter int unsigned DLY_C11 = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_in,
   input  logic       fb_in,
   input  logic [1:0] width_code,
   output logic       up_o,
   output logic       dn_o
);

   import pfd_pkg::*;

   localparam int unsigned MAX_D = max4(DLY_C00, DLY_C01, DLY_C10, DLY_C11);
   localparam int unsigned CNT_W = (MAX_D > 1) ? $clog2(MAX_D) : 1;

   generate
      if (DLY_C00 < 1 || DLY_C01 < 1 || DLY_C10 < 1 || DLY_C11 < 1) begin : g_bad_dly
         $error("pfd_antibacklash: every overlap length must be at least one cycle");
      end
   endgenerate

   logic [N_CH-1:0]  lvl;
   logic [N_CH-1:0]  ev;
   logic [N_CH-1:0]  q;
   logic             busy;
   logic             expire;
   logic [CNT_W-1:0] dly_m1;

   assign lvl[CH_REF] = ref_in;
   assign lvl[CH_FB]  = fb_in;

   pfd_edge_det #(.N(N_CH)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .rise  (ev)
   );

   assign busy = &q;

   always_comb begin
      dly_m1 = CNT_W'(pick_dly(width_code, DLY_C00, DLY_C01, DLY_C10, DLY_C11) - 1);
   end

   pfd_dly_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .load_m1 (dly_m1),
      .expire  (expire)
   );

   generate
      for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
         pfd_chan_ff u_ff (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev     (ev[ch]),
            .busy   (busy),
            .expire (expire),
            .q      (q[ch])
         );
      end
   endgenerate

   assign up_o = q[CH_REF];
   assign dn_o = q[CH_FB];

endmodule

// File: rtl/pfd_antibacklash_chk.sv
module pfd_antibacklash_chk #(
   parameter int unsigned DLY_C00 = 2,
   parameter int unsigned DLY_C01 = 1,
   parameter int unsigned DLY_C10 = 4,
   parameter int unsigned DLY_C11 = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] width_code,
   input logic       up_o,
   input logic       dn_o
);

   import pfd_pkg::*;

   logic       both;
   logic       both_q;
   logic [1:0] code_q;
   logic [7:0] run;
   logic [7:0] exp_len;

   assign both = up_o & dn_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         both_q  <= 1'b0;
         code_q  <= 2'b00;
         run     <= '0;
         exp_len <= '0;
      end else begin
         both_q <= both;
         code_q <= width_code;
         if (both && !both_q) begin
            run     <= 8'd1;
            exp_len <= 8'(pick_dly(code_q, DLY_C00, DLY_C01, DLY_C10, DLY_C11));
         end else if (both) begin
            run <= run + 8'd1;
         end
      end
   end

   AST_UP_FALLS_WITH_DN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(up_o) |-> $fell(dn_o)); // R5
   AST_DN_FALLS_WITH_UP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dn_o) |-> $fell(up_o)); // R5
   AST_UP_WAITS_FOR_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (up_o && !dn_o) |=> up_o); // R2
   AST_DN_WAITS_FOR_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_o && !up_o) |=> dn_o); // R3
   AST_OVERLAP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      (both_q && !both) |-> (run == exp_len)); // R10

endmodule

bind pfd_antibacklash pfd_antibacklash_chk #(
   .DLY_C00 (DLY_C00),
   .DLY_C01 (DLY_C01),
   .DLY_C10 (DLY_C10),
   .DLY_C11 (DLY_C11)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .width_code (width_code),
   .up_o       (up_o),
   .dn_o       (dn_o)
);

// File: tb/pfd_antibacklash_tb_top.sv
module pfd_antibacklash_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic       fb_in = 1'b0;
   logic [1:0] width_code = 2'b00;
   logic       up_o;
   logic       dn_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfd_antibacklash dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_in     (ref_in),
      .fb_in      (fb_in),
      .width_code (width_code),
      .up_o       (up_o),
      .dn_o       (dn_o)
   );

   // Overlap length per code, from the requirements (R5).
   function automatic int exp_dly(input logic [1:0] c);
      case (c)
         2'b00:   return 2;
         2'b01:   return 1;
         2'b10:   return 4;
         default: return 2;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int got, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s got=%0h exp=%0h", req, got, expv);
      end
   endtask

   // Bench model state
   logic m_pr, m_pf, m_up, m_dn, m_hu, m_hd;
   int   m_run, m_d;

   task automatic model_clear();
      m_pr = 0; m_pf = 0; m_up = 0; m_dn = 0; m_hu = 0; m_hd = 0;
      m_run = 0; m_d = 1;
   endtask

   task automatic model_step(input logic r, input logic f, input logic [1:0] c);
      logic er, ef, nu, nd;
      er = r & ~m_pr;
      ef = f & ~m_pf;
      m_pr = r;
      m_pf = f;
      if (m_up && m_dn) begin
         m_run++;
         if (er) m_hu = 1;
         if (ef) m_hd = 1;
         if (m_run == m_d) begin
            m_up = 0;
            m_dn = 0;
         end
      end else begin
         nu = m_up | er | m_hu;
         nd = m_dn | ef | m_hd;
         m_hu = 0;
         m_hd = 0;
         if (nu && nd) begin
            m_run = 0;
            m_d = exp_dly(c);
         end
         m_up = nu;
         m_dn = nd;
      end
   endtask

   task automatic do_reset();
      rst_n  = 1'b0;
      ref_in = 1'b0;
      fb_in  = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      model_clear();
   endtask

   // Leader rises at sample 0, follower k samples later (k=0: together).
   task automatic skew_test(input logic [1:0] c, input bit ref_leads, input int k, input string req);
      logic [15:0] lead_s, foll_s, lead_e, foll_e;
      int d;
      do_reset();
      width_code = c;
      d = exp_dly(c);
      lead_s = '0; foll_s = '0; lead_e = '0; foll_e = '0;
      if (ref_leads) ref_in = 1'b1; else fb_in = 1'b1;
      if (k == 0) begin ref_in = 1'b1; fb_in = 1'b1; end
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         lead_s[i] = ref_leads ? up_o : dn_o;
         foll_s[i] = ref_leads ? dn_o : up_o;
         lead_e[i] = (i <= k + d);
         foll_e[i] = (i >= k + 1) && (i <= k + d);
         if (i == k) begin ref_in = 1'b1; fb_in = 1'b1; end
      end
      chk(lead_s == lead_e, {req, " leading output"}, lead_s, lead_e);
      chk(foll_s == foll_e, {req, " lagging output"}, foll_s, foll_e);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [15:0] us, ds, ue, de;
      int unsigned seed;
      int unsigned rv;
      model_clear();

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(up_o == 0 && dn_o == 0, "R1 outputs low in reset", {up_o, dn_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      ref_in = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(up_o == 0, "R1 reset clears raised up", up_o, 0);

      // R2: reference alone
      do_reset();
      ref_in = 1'b1;
      us = '0; ds = '0;
      for (int i = 1; i <= 6; i++) begin
         @(negedge clk);
         us[i] = up_o; ds[i] = dn_o;
      end
      chk(us == 16'h007e && ds == 0, "R2 up alone held", {us, ds}, 32'h007e_0000);

      // R3: feedback alone
      do_reset();
      fb_in = 1'b1;
      us = '0; ds = '0;
      for (int i = 1; i <= 6; i++) begin
         @(negedge clk);
         us[i] = up_o; ds[i] = dn_o;
      end
      chk(ds == 16'h007e && us == 0, "R3 dn alone held", {ds, us}, 32'h007e_0000);

      // R6 / R5 / R4: coincident edges, every code, inputs held high afterwards
      for (int c = 0; c < 4; c++) begin
         skew_test(2'(c), 1'b1, 0, "R6 R5 R4 lock");
      end

      // R7: reference leads / feedback leads
      skew_test(2'b01, 1'b1, 3, "R7 ref leads k=3");
      skew_test(2'b10, 1'b0, 2, "R7 fb leads k=2");
      skew_test(2'b00, 1'b1, 5, "R7 ref leads k=5");

      // R8: edge during the delay is held and applied after the clear
      do_reset();
      width_code = 2'b10;
      ref_in = 1'b1; fb_in = 1'b1;
      us = '0; ds = '0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         us[i] = up_o; ds[i] = dn_o;
         if (i == 1) ref_in = 1'b0;
         if (i == 2) ref_in = 1'b1;
      end
      ue = 16'h01de; de = 16'h001e;
      chk(us == ue, "R8 held up re-set after clear", us, ue);
      chk(ds == de, "R8 dn not re-set", ds, de);

      // R9: doubled reference edge before feedback
      do_reset();
      width_code = 2'b01;
      ref_in = 1'b1;
      us = '0; ds = '0;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         us[i] = up_o; ds[i] = dn_o;
         if (i == 1) ref_in = 1'b0;
         if (i == 2) ref_in = 1'b1;
         if (i == 3) ref_in = 1'b0;
         if (i == 5) fb_in = 1'b1;
      end
      ue = 16'h007e; de = 16'h0040;
      chk(us == ue, "R9 second ref edge ignored (up)", us, ue);
      chk(ds == de, "R9 second ref edge ignored (dn)", ds, de);

      // R10: code change during the delay
      do_reset();
      width_code = 2'b10;
      ref_in = 1'b1; fb_in = 1'b1;
      us = '0; ds = '0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         us[i] = up_o; ds[i] = dn_o;
         if (i == 1) width_code = 2'b01;
      end
      ue = 16'h001e;
      chk(us == ue && ds == ue, "R10 delay fixed at pairing", {us, ds}, {ue, ue});

      // Random phase against the bench model (R2 R3 R5 R8 R9)
      seed = 32'h5eed_1234;
      rv = $urandom(seed);
      do_reset();
      for (int cyc = 0; cyc < 4000; cyc++) begin
         @(negedge clk);
         chk(up_o == m_up && dn_o == m_dn, "R5 R8 R9 random vs model",
             {up_o, dn_o}, {m_up, m_dn});
         rv = $urandom();
         if (rv % 5 == 0) ref_in = ~ref_in;
         if ((rv >> 4) % 5 == 0) fb_in = ~fb_in;
         if ((rv >> 8) % 64 == 0) width_code = 2'(rv >> 16);
         model_step(ref_in, fb_in, width_code);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule